// File: doc/BRIEF.md
# Per-CPU Interrupt Delivery, Acknowledge and End-of-Interrupt Unit

This unit sits between a bank of interrupt source registers and one processor. It keeps two bit-vectors over every source. The pending set holds sources that were requested and not yet acknowledged. The in-service set holds sources the processor has taken and not yet retired. A 4-bit task priority register filters incoming requests. An 8-bit spurious vector register supplies the answer when nothing valid can be delivered. The unit drives a single interrupt line towards the processor.

The source bank supplies each source's priority, vector, sense mode and activity on flat input buses. When this unit decides that a source's activity must be dropped, it returns a one-cycle clear strobe for that source. An acknowledge read picks the highest-priority pending source. Ties go to the lowest index. The read returns either that source's vector or the spurious vector. An end-of-interrupt write retires the highest-priority in-service source, and it can raise the line again when a pending source now outranks what is still in service. Within one cycle, acknowledge and end-of-interrupt are resolved first and a new request after them.

Top module: `cpu_irq_deliver`

## Requirements
- R1: After reset the task priority is 15, the spurious vector is 0xFF, both sets are empty and `irq_out` is low. A request at priority 15 is then refused, because 15 is not greater than 15.
- R2: A request is accepted into the pending set only when the source priority is strictly greater than the task priority. A request at equal or lower priority leaves the state and `irq_out` unchanged.
- R3: A request for a source that is already pending is ignored.
- R4: An accepted request drives `irq_out` high on the next cycle when the pending set is empty, or when its priority is strictly greater than the highest priority already pending. Otherwise `irq_out` keeps its value.
- R5: Selection takes the highest priority among the members of a set. On equal priorities the lowest source index wins.
- R6: An acknowledge with an empty pending set returns the spurious vector, pulses no clear strobe and changes no state.
- R7: When the selected source is inactive, or its priority is no longer greater than the task priority, the acknowledge returns the spurious vector. It pulses that source's bit of `act_clr` and removes the source from the pending set, and the source does not enter service.
- R8: Otherwise the acknowledge returns the source's own vector, moves the source from pending to in-service, and pulses its `act_clr` bit only when the source is edge-sensitive (`src_level` bit = 0). A level-sensitive source (`src_level` bit = 1) gets no clear strobe. The vector and the strobes are valid in the same cycle as `ack_rd`.
- R9: `irq_out` is low in the cycle after any acknowledge, unless a request or end-of-interrupt in that same cycle qualifies to raise it.
- R10: An end-of-interrupt removes the highest-priority in-service source. It drives `irq_out` high when the highest pending priority is strictly greater than the highest remaining in-service priority, or when a source is pending and nothing remains in service.
- R11: When a request coincides with an acknowledge, the acknowledge is applied first. A request for the source that was just acknowledged is therefore accepted again, and it raises `irq_out`.
- R12: A write on `tp_wr` loads the task priority, and a write on `spur_wr` loads the spurious vector. Either new value governs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_prio | input | NUM_SRC*4 | Priority of each source, source i at bits [4i+3:4i] |
| src_vec | input | NUM_SRC*VEC_W | Vector of each source, source i at slice i |
| src_level | input | NUM_SRC | Sense mode per source: 1 level, 0 edge |
| src_active | input | NUM_SRC | Activity flag per source from the source bank |
| req_valid | input | 1 | A source requests delivery this cycle |
| req_src | input | IDX_W | Index of the requesting source |
| tp_wr | input | 1 | Load the task priority |
| tp_wdata | input | 4 | New task priority |
| spur_wr | input | 1 | Load the spurious vector |
| spur_wdata | input | VEC_W | New spurious vector |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_vec | output | VEC_W | Vector returned by the acknowledge, valid while ack_rd is high |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| act_clr | output | NUM_SRC | One-cycle activity clear strobes back to the source bank |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The acknowledge result (`ack_vec` and `act_clr`) is combinational. It is due in the same cycle that `ack_rd` is high. The bench therefore drives each strobe just after a rising edge and samples these outputs at the following falling edge, before the state changes. `irq_out` and the two sets are registered, so the effect of a request, acknowledge, end-of-interrupt or register write appears one edge later. The bench checks it at the next falling edge. A behavioural reference model advances on every rising edge from the same inputs. It is compared with `irq_out`, `act_clr` and, during acknowledges, `ack_vec` at every falling edge. Fixed expected vectors and line levels are checked at the points the scenarios call out.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;

    localparam int PRIO_W    = 4;
    localparam int IDX_W_MAX = 8;

    typedef logic [PRIO_W-1:0] prio_t;

    localparam prio_t TP_RESET = '1;

    // Result of a highest-priority scan over one set.
    typedef struct packed {
        logic                 found;
        logic [IDX_W_MAX-1:0] idx;
        prio_t                prio;
    } pick_t;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_EMPTY,
        ACK_STALE,
        ACK_TAKE
    } ack_kind_e;

    // True when priority p beats the winner of a scan (or the scan was empty).
    function automatic logic beats(prio_t p, pick_t other);
        return !other.found || (p > other.prio);
    endfunction

    // True when scan a found something that outranks scan b.
    function automatic logic outranks(pick_t a, pick_t b);
        return a.found && beats(a.prio, b);
    endfunction

endpackage

// File: rtl/dlv_prio_pick.sv
module dlv_prio_pick
    import irq_dlv_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]        member,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output pick_t                     best
);

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (member[i] && (!best.found || prio_flat[i*PRIO_W +: PRIO_W] > best.prio)) begin
                best.found = 1'b1;
                best.idx   = IDX_W_MAX'(i);
                best.prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/dlv_ack_resolve.sv
module dlv_ack_resolve
    import irq_dlv_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    parameter  int VEC_W   = 8,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     ack_rd,
    input  pick_t                    sel,
    input  logic [NUM_SRC-1:0]       src_active,
    input  logic [NUM_SRC-1:0]       src_level,
    input  logic [NUM_SRC*VEC_W-1:0] vec_flat,
    input  prio_t                    task_prio,
    input  logic [VEC_W-1:0]         spur_vec,
    output logic [VEC_W-1:0]         vec_out,
    output logic [NUM_SRC-1:0]       act_clr,
    output logic [NUM_SRC-1:0]       pend_drop,
    output logic [NUM_SRC-1:0]       svc_add
);

    ack_kind_e          kind;
    logic [IDX_W-1:0]   sidx;
    logic [NUM_SRC-1:0] sel_bit;
    logic               unused_sel;

    assign sidx       = sel.idx[IDX_W-1:0];
    assign sel_bit    = sel.found ? (NUM_SRC'(1) << sidx) : '0;
    assign unused_sel = ^sel.idx;

    always_comb begin
        kind = ACK_IDLE;
        if (ack_rd) begin
            if (!sel.found)
                kind = ACK_EMPTY;
            else if (!src_active[sidx] || !(sel.prio > task_prio))
                kind = ACK_STALE;
            else
                kind = ACK_TAKE;
        end
    end

    always_comb begin
        vec_out   = spur_vec;
        act_clr   = '0;
        pend_drop = '0;
        svc_add   = '0;
        case (kind)
            ACK_STALE: begin
                act_clr   = sel_bit;
                pend_drop = sel_bit;
            end
            ACK_TAKE: begin
                vec_out   = vec_flat[sidx*VEC_W +: VEC_W];
                pend_drop = sel_bit;
                svc_add   = sel_bit;
                if (!src_level[sidx])
                    act_clr = sel_bit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_irq_deliver.sv
module cpu_irq_deliver
    import irq_dlv_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    parameter  int VEC_W   = 8,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC*4-1:0]     src_prio,
    input  logic [NUM_SRC*VEC_W-1:0] src_vec,
    input  logic [NUM_SRC-1:0]       src_level,
    input  logic [NUM_SRC-1:0]       src_active,
    input  logic                     req_valid,
    input  logic [IDX_W-1:0]         req_src,
    input  logic                     tp_wr,
    input  logic [3:0]               tp_wdata,
    input  logic                     spur_wr,
    input  logic [VEC_W-1:0]         spur_wdata,
    input  logic                     ack_rd,
    output logic [VEC_W-1:0]         ack_vec,
    input  logic                     eoi_wr,
    output logic [NUM_SRC-1:0]       act_clr,
    output logic                     irq_out
);

    logic [NUM_SRC-1:0] raised_q, inserv_q;
    prio_t              tp_q;
    logic [VEC_W-1:0]   spur_q;
    logic               irq_q;

    logic [NUM_SRC-1:0] pend_drop, svc_add, eoi_clr, req_bit;
    logic [NUM_SRC-1:0] raised_mid, raised_nxt, inserv_nxt;
    pick_t              pend_now, svc_now, pend_mid, svc_nxt;
    prio_t              req_prio;
    logic               req_ok, irq_nxt;
    logic               unused_bits;

    // Scans over the sets at the start of the cycle.
    dlv_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick_pend (
        .member(raised_q), .prio_flat(src_prio), .best(pend_now));
    dlv_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick_svc (
        .member(inserv_q), .prio_flat(src_prio), .best(svc_now));

    dlv_ack_resolve #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_ack (
        .ack_rd     (ack_rd),
        .sel        (pend_now),
        .src_active (src_active),
        .src_level  (src_level),
        .vec_flat   (src_vec),
        .task_prio  (tp_q),
        .spur_vec   (spur_q),
        .vec_out    (ack_vec),
        .act_clr    (act_clr),
        .pend_drop  (pend_drop),
        .svc_add    (svc_add)
    );

    // Retire the top in-service source, then add the acknowledged one.
    assign eoi_clr    = (eoi_wr && svc_now.found) ?
                        (NUM_SRC'(1) << svc_now.idx[IDX_W-1:0]) : '0;
    assign raised_mid = raised_q & ~pend_drop;
    assign inserv_nxt = (inserv_q & ~eoi_clr) | svc_add;

    // Scans over the sets after acknowledge and end-of-interrupt.
    dlv_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick_pend_mid (
        .member(raised_mid), .prio_flat(src_prio), .best(pend_mid));
    dlv_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick_svc_nxt (
        .member(inserv_nxt), .prio_flat(src_prio), .best(svc_nxt));

    // A new request is resolved last.
    assign req_prio   = src_prio[req_src*PRIO_W +: PRIO_W];
    assign req_bit    = NUM_SRC'(1) << req_src;
    assign req_ok     = req_valid && (req_prio > tp_q) && !raised_mid[req_src];
    assign raised_nxt = raised_mid | (req_ok ? req_bit : '0);

    always_comb begin
        irq_nxt = irq_q;
        if (ack_rd)
            irq_nxt = 1'b0;
        if (eoi_wr && outranks(pend_mid, svc_nxt))
            irq_nxt = 1'b1;
        if (req_ok && beats(req_prio, pend_mid))
            irq_nxt = 1'b1;
    end

    assign unused_bits = ^{pend_mid.idx, svc_nxt.idx, svc_now.prio, svc_now.idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            raised_q <= '0;
            inserv_q <= '0;
            tp_q     <= TP_RESET;
            spur_q   <= '1;
            irq_q    <= 1'b0;
        end else begin
            raised_q <= raised_nxt;
            inserv_q <= inserv_nxt;
            irq_q    <= irq_nxt;
            if (tp_wr)
                tp_q <= tp_wdata;
            if (spur_wr)
                spur_q <= spur_wdata;
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/dlv_checker.sv
module dlv_checker #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               ack_rd,
    input logic               eoi_wr,
    input logic [NUM_SRC-1:0] act_clr,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] raised_q,
    input logic [NUM_SRC-1:0] inserv_q,
    input logic [VEC_W-1:0]   ack_vec,
    input logic [VEC_W-1:0]   spur_q
);

    assert_pend_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        (raised_q & ~$past(raised_q)) != '0 |-> $past(req_valid));

    assert_irq_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(req_valid || eoi_wr));

    assert_spur_on_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && raised_q == '0) |-> (ack_vec == spur_q && act_clr == '0));

    assert_clr_only_on_ack_R7: assert property (@(posedge clk) disable iff (rst)
        !ack_rd |-> act_clr == '0);

    assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_clr));

    assert_svc_grows_on_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (inserv_q & ~$past(inserv_q)) != '0 |-> $past(ack_rd));

    assert_irq_drop_on_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !req_valid && !eoi_wr) |=> !irq_out);

    assert_svc_shrinks_on_eoi_R10: assert property (@(posedge clk) disable iff (rst)
        ($countones(inserv_q) < $countones($past(inserv_q))) |-> $past(eoi_wr));

endmodule

bind cpu_irq_deliver dlv_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ack_rd    (ack_rd),
    .eoi_wr    (eoi_wr),
    .act_clr   (act_clr),
    .irq_out   (irq_out),
    .raised_q  (raised_q),
    .inserv_q  (inserv_q),
    .ack_vec   (ack_vec),
    .spur_q    (spur_q)
);

// File: tb/cpu_irq_deliver_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_deliver_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N*4-1:0] src_prio;
    logic [N*8-1:0] src_vec;
    logic [N-1:0] src_level;
    logic [N-1:0] src_active;
    logic         req = 1'b0;
    logic [2:0]   rid = '0;
    logic         tpw = 1'b0;
    logic [3:0]   tpd = '0;
    logic         spw = 1'b0;
    logic [7:0]   spd = '0;
    logic         ack = 1'b0;
    logic         eoi = 1'b0;
    logic [7:0]   ack_vec;
    logic [N-1:0] act_clr;
    logic         irq_out;

    logic [3:0] prio_a [N];
    logic [7:0] vec_a  [N];
    logic       lvl_a  [N];
    logic       act_a  [N];

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    // Reference model state
    logic [N-1:0] m_raised, m_inserv;
    int           m_tp;
    logic [7:0]   m_spur;
    logic         m_irq;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            src_prio[i*4 +: 4] = prio_a[i];
            src_vec[i*8 +: 8]  = vec_a[i];
            src_level[i]       = lvl_a[i];
            src_active[i]      = act_a[i];
        end
    end

    cpu_irq_deliver #(.NUM_SRC(N), .VEC_W(8)) dut_i (
        .clk(clk), .rst(rst),
        .src_prio(src_prio), .src_vec(src_vec),
        .src_level(src_level), .src_active(src_active),
        .req_valid(req), .req_src(rid),
        .tp_wr(tpw), .tp_wdata(tpd),
        .spur_wr(spw), .spur_wdata(spd),
        .ack_rd(ack), .ack_vec(ack_vec),
        .eoi_wr(eoi), .act_clr(act_clr), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Highest priority member of a set, lowest index on ties; -1 if empty.
    function automatic int top_of(logic [N-1:0] set);
        int k = -1;
        for (int i = 0; i < N; i++)
            if (set[i] && (k < 0 || prio_a[i] > prio_a[k]))
                k = i;
        return k;
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] r, s;
        logic nirq;
        int ka, ke, kr, kq;
        if (rst) begin
            m_raised = '0; m_inserv = '0; m_tp = 15; m_spur = 8'hFF; m_irq = 1'b0;
        end else begin
            r = m_raised; s = m_inserv; nirq = m_irq;
            ka = top_of(m_raised);
            ke = top_of(m_inserv);
            if (eoi && ke >= 0) s[ke] = 1'b0;
            if (ack) begin
                nirq = 1'b0;
                if (ka >= 0) begin
                    if (act_a[ka] && int'(prio_a[ka]) > m_tp) s[ka] = 1'b1;
                    r[ka] = 1'b0;
                end
            end
            if (eoi) begin
                kr = top_of(r); kq = top_of(s);
                if (kr >= 0 && (kq < 0 || prio_a[kr] > prio_a[kq])) nirq = 1'b1;
            end
            if (req && int'(prio_a[rid]) > m_tp && !r[rid]) begin
                kr = top_of(r);
                if (kr < 0 || prio_a[rid] > prio_a[kr]) nirq = 1'b1;
                r[rid] = 1'b1;
            end
            if (tpw) m_tp = int'(tpd);
            if (spw) m_spur = spd;
            m_raised = r; m_inserv = s; m_irq = nirq;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        int k;
        logic [7:0] ev;
        logic [N-1:0] ec;
        if (!rst) begin
            k = top_of(m_raised);
            ev = m_spur; ec = '0;
            if (ack && k >= 0) begin
                if (!act_a[k] || !(int'(prio_a[k]) > m_tp)) ec[k] = 1'b1;
                else begin
                    ev = vec_a[k];
                    if (!lvl_a[k]) ec[k] = 1'b1;
                end
            end
            check(irq_out == m_irq, phase, "model irq_out", irq_out, m_irq);
            check(act_clr == ec, phase, "model act_clr", act_clr, ec);
            if (ack) check(ack_vec == ev, phase, "model ack_vec", ack_vec, ev);
        end
    end

    task automatic op(input bit r, input int id, input bit a, input bit e);
        @(posedge clk); #1;
        req = r; rid = 3'(id); ack = a; eoi = e;
        @(posedge clk); #1;
        req = 1'b0; ack = 1'b0; eoi = 1'b0;
    endtask

    task automatic raise(input int id);
        op(1'b1, id, 1'b0, 1'b0);
    endtask

    task automatic do_eoi();
        op(1'b0, 0, 1'b0, 1'b1);
    endtask

    task automatic ack_expect(input int v, input int c, input string tag);
        @(posedge clk); #1;
        ack = 1'b1;
        @(negedge clk);
        check(ack_vec == 8'(v), tag, "ack_vec", ack_vec, v);
        check(act_clr == N'(c), tag, "act_clr", act_clr, c);
        @(posedge clk); #1;
        ack = 1'b0;
    endtask

    task automatic expect_irq(input bit v, input string tag);
        @(negedge clk);
        check(irq_out == v, tag, "irq_out", irq_out, v);
    endtask

    task automatic set_tp(input int v);
        @(posedge clk); #1; tpw = 1'b1; tpd = 4'(v);
        @(posedge clk); #1; tpw = 1'b0;
    endtask

    task automatic set_spur(input int v);
        @(posedge clk); #1; spw = 1'b1; spd = 8'(v);
        @(posedge clk); #1; spw = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=0", checks);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            prio_a[i] = 4'd0; vec_a[i] = 8'h40 + 8'(i); lvl_a[i] = 1'b0; act_a[i] = 1'b1;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state, request at 15 refused
        phase = "R1";
        expect_irq(1'b0, "R1");
        ack_expect(8'hFF, 0, "R1");
        prio_a[3] = 4'd15;
        raise(3);
        expect_irq(1'b0, "R1");
        ack_expect(8'hFF, 0, "R1");

        // R12, R6: register writes, empty acknowledge
        phase = "R12";
        set_tp(0);
        set_spur(8'h5A);
        ack_expect(8'h5A, 0, "R6");

        // R2: strict comparison with task priority
        phase = "R2";
        set_tp(4);
        prio_a[1] = 4'd4;
        raise(1);
        expect_irq(1'b0, "R2");
        prio_a[1] = 4'd5;
        raise(1);
        expect_irq(1'b1, "R2");
        phase = "R8";
        ack_expect(8'h41, 8'h02, "R8");
        expect_irq(1'b0, "R9");
        do_eoi();
        expect_irq(1'b0, "R10");
        set_tp(0);

        // R5: priority order and tie break
        phase = "R5";
        prio_a[2] = 4'd6; prio_a[6] = 4'd6; prio_a[4] = 4'd3;
        raise(6); raise(4); raise(2);
        expect_irq(1'b1, "R4");
        ack_expect(8'h42, 8'h04, "R5");
        ack_expect(8'h46, 8'h40, "R5");
        ack_expect(8'h44, 8'h10, "R5");
        ack_expect(8'h5A, 0, "R6");
        do_eoi(); do_eoi(); do_eoi();

        // R4, R3: raise rule against the pending set
        phase = "R4";
        prio_a[0] = 4'd3; prio_a[5] = 4'd5; prio_a[7] = 4'd2; prio_a[3] = 4'd3; prio_a[1] = 4'd4;
        raise(0);
        expect_irq(1'b1, "R4");
        raise(5);
        ack_expect(8'h45, 8'h20, "R4");
        expect_irq(1'b0, "R9");
        raise(7);
        expect_irq(1'b0, "R4");
        raise(3);
        expect_irq(1'b0, "R4");
        raise(1);
        expect_irq(1'b1, "R4");
        ack_expect(8'h41, 8'h02, "R4");
        phase = "R3";
        raise(3);
        expect_irq(1'b0, "R3");
        ack_expect(8'h40, 8'h01, "R3");
        ack_expect(8'h43, 8'h08, "R3");
        ack_expect(8'h47, 8'h80, "R3");
        ack_expect(8'h5A, 0, "R3");
        repeat (5) do_eoi();

        // R8: level source keeps activity; R7: stale acknowledges
        phase = "R8";
        lvl_a[2] = 1'b1;
        raise(2);
        ack_expect(8'h42, 0, "R8");
        do_eoi();
        phase = "R7";
        act_a[4] = 1'b0;
        raise(4);
        ack_expect(8'h5A, 8'h10, "R7");
        act_a[4] = 1'b1;
        raise(5);
        set_tp(6);
        ack_expect(8'h5A, 8'h20, "R7");
        set_tp(0);
        ack_expect(8'h5A, 0, "R7");

        // R10: retire order and re-raise
        phase = "R10";
        lvl_a[2] = 1'b0;
        prio_a[6] = 4'd6; prio_a[1] = 4'd4; prio_a[2] = 4'd5; prio_a[7] = 4'd5;
        raise(6);
        ack_expect(8'h46, 8'h40, "R10");
        raise(1);
        ack_expect(8'h41, 8'h02, "R10");
        raise(2); raise(7);
        ack_expect(8'h42, 8'h04, "R10");
        do_eoi();
        expect_irq(1'b0, "R10");
        do_eoi();
        expect_irq(1'b1, "R10");
        ack_expect(8'h47, 8'h80, "R10");
        do_eoi(); do_eoi();

        // R11: acknowledge before request in the same cycle
        phase = "R11";
        prio_a[3] = 4'd3;
        raise(3);
        op(1'b1, 3, 1'b1, 1'b0);
        expect_irq(1'b1, "R11");
        ack_expect(8'h43, 8'h08, "R11");
        ack_expect(8'h5A, 0, "R11");
        expect_irq(1'b0, "R9");

        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule